// File: doc/BRIEF.md
# Threshold-Triggered Waveform Chunk Extractor

This block sits behind a multi-channel digitiser whose channels share one sample bus in turns, each channel producing 10-bit samples. It keeps nothing of a channel's waveform unless a sample rises above that channel's programmable threshold. When that happens it opens a chunk. The chunk starts with the two samples that came before the crossing and continues with every following sample. It closes on the first sample that falls back to or below the threshold, which becomes the trailing sample. A chunk that reaches the length limit is closed at that point.

Each closed chunk leaves the block as a header word followed by its samples. The header holds the channel number, the frame index at which the first stored sample was taken, and the number of samples. Chunks go out in the order in which they closed, and the words of one chunk are never interleaved with another chunk. A downstream event builder can therefore match chunks to triggers using only the header timestamps.

A channel whose previous chunk has not yet fully left the block cannot start a new chunk. Its delay line still advances during that time.

Top module: `wave_chunker`

## Requirements
- R1: After reset `out_valid` is 0 and every channel's threshold is all ones, so no sample can open a chunk until a threshold is written.
- R2: A chunk opens only on a sample strictly greater than its channel's threshold; a sample equal to the threshold does not open one.
- R3: A chunk holds, in order, the channel's two samples preceding the opening sample, the opening sample, every following sample, and ends with the first sample not above threshold, which is included.
- R4: A header word has `out_hdr`=1 and holds the channel in bits [30:26], the timestamp in bits [25:6] and the sample count in bits [5:0]; sample words carry the sample in bits [9:0] with upper bits 0 and `out_hdr`=0.
- R5: The frame index counts samples taken on channel NCH-1 since reset, modulo 2^20; a chunk's timestamp is the frame index of its opening sample minus 2.
- R6: A chunk that reaches 32 samples is closed with that sample even if it is still above threshold.
- R7: Chunks leave in closing order; the header appears two clocks after the clock that accepted the closing sample, the chunk's words follow on consecutive clocks, and at least one idle clock separates two chunks.
- R8: A crossing on a channel whose previous chunk has not yet had its last word presented on the output is ignored, while that channel's delay line keeps advancing.
- R9: Writing `thr_we` sets the threshold of channel `thr_ch` from the next clock on and leaves every other channel's threshold unchanged.
- R10: Channels are tracked independently, so pulses on several channels in the same frames yield separate, correct chunks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A sample is present on the bus |
| in_chan | input | 5 | Channel of the present sample |
| in_data | input | 10 | Sample value |
| thr_we | input | 1 | Threshold write strobe |
| thr_ch | input | 5 | Channel whose threshold is written |
| thr_val | input | 10 | New threshold value |
| out_valid | output | 1 | An output word is present |
| out_hdr | output | 1 | The present word is a chunk header |
| out_data | output | 31 | Header or sample word |

## Verification
Chunk closing and draining can fall in the same cycle. One channel's trailing or capped sample can arrive while another chunk is still being emitted, and a channel's new crossing can arrive in the very cycle in which its previous chunk's last word goes out. The bench provokes both cases with back-to-back pulses on several channels and with a long pulse that hits the length limit and stays high. A behavioural model built on queues decides for every clock which words must appear, in what order, and which crossings must be discarded, and the bench compares the outputs against that model on every cycle.

// File: rtl/wave_chunker.sv
module wave_chunker #(
  parameter int NCH  = 32,
  parameter int SW   = 10,
  parameter int MAXS = 32,
  parameter int TSW  = 20
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [4:0]           in_chan,
  input  logic [SW-1:0]        in_data,
  input  logic                 thr_we,
  input  logic [4:0]           thr_ch,
  input  logic [SW-1:0]        thr_val,
  output logic                 out_valid,
  output logic                 out_hdr,
  output logic [30:0]          out_data
);
  localparam int CHW  = $clog2(NCH);
  localparam int CW   = $clog2(MAXS + 1);
  localparam int BODY = MAXS - 2;
  localparam int AW   = $clog2(NCH * BODY);
  localparam int HW   = CHW + TSW + CW;

  logic [SW-1:0]  thr [NCH];
  logic [SW-1:0]  d1 [NCH];
  logic [SW-1:0]  d2 [NCH];
  logic [SW-1:0]  pa [NCH];
  logic [SW-1:0]  pb [NCH];
  logic [SW-1:0]  body [NCH*BODY];
  logic [CW-1:0]  cnt [NCH];
  logic [TSW-1:0] ts [NCH];
  logic [NCH-1:0] act, pend;
  logic [TSW-1:0] frame;

  logic [CHW-1:0] q [NCH];
  logic [CHW-1:0] qwr, qrd;
  logic [CHW:0]   qn;

  logic           busy;
  logic [CHW-1:0] dch;
  logic [CW-1:0]  didx;

  logic [CHW-1:0] c;
  logic           above, open, grow, close, pop;
  logic [CW-1:0]  ncnt;
  logic [AW-1:0]  wa, ra;
  logic [HW-1:0]  word;

  assign c     = in_chan[CHW-1:0];
  assign above = in_data > thr[c];
  assign open  = in_valid && !act[c] && above && !pend[c];
  assign grow  = in_valid && act[c];
  assign ncnt  = cnt[c] + 1'b1;
  assign close = grow && (!above || ncnt == CW'(MAXS));
  assign pop   = !busy && qn != 0;
  assign wa    = AW'(int'(c) * BODY + (act[c] ? int'(cnt[c]) - 2 : 0));
  assign ra    = AW'(int'(dch) * BODY + (didx >= CW'(3) ? int'(didx) - 3 : 0));

  always_comb begin
    if (didx == '0)      word = {dch, ts[dch], cnt[dch]};
    else if (didx == 1)  word = HW'(pa[dch]);
    else if (didx == 2)  word = HW'(pb[dch]);
    else                 word = HW'(body[ra]);
  end

  always_ff @(posedge clk)
    if (open || grow) body[wa] <= in_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NCH; i++) begin
        thr[i] <= '1; d1[i] <= '0; d2[i] <= '0;
        pa[i] <= '0; pb[i] <= '0; cnt[i] <= '0; ts[i] <= '0; q[i] <= '0;
      end
      act <= '0; pend <= '0; frame <= '0;
      qwr <= '0; qrd <= '0; qn <= '0;
      busy <= 1'b0; dch <= '0; didx <= '0;
      out_valid <= 1'b0; out_hdr <= 1'b0; out_data <= '0;
    end else begin
      if (in_valid) begin
        d2[c] <= d1[c];
        d1[c] <= in_data;
        if (int'(in_chan) == NCH - 1) frame <= frame + 1'b1;
      end
      if (open) begin
        pa[c]  <= d2[c];
        pb[c]  <= d1[c];
        cnt[c] <= CW'(3);
        ts[c]  <= frame - TSW'(2);
        act[c] <= 1'b1;
      end else if (grow) begin
        cnt[c] <= ncnt;
        if (close) begin
          act[c]  <= 1'b0;
          pend[c] <= 1'b1;
          q[qwr]  <= c;
          qwr     <= (int'(qwr) == NCH - 1) ? '0 : qwr + 1'b1;
        end
      end
      if (thr_we) thr[thr_ch[CHW-1:0]] <= thr_val;

      out_valid <= busy;
      out_hdr   <= busy && didx == '0;
      out_data  <= 31'(word);
      if (pop) begin
        busy <= 1'b1;
        dch  <= q[qrd];
        didx <= '0;
        qrd  <= (int'(qrd) == NCH - 1) ? '0 : qrd + 1'b1;
      end else if (busy) begin
        if (didx == cnt[dch]) begin
          busy      <= 1'b0;
          pend[dch] <= 1'b0;
        end else begin
          didx <= didx + 1'b1;
        end
      end
      qn <= qn + (close ? 1'b1 : 1'b0) - (pop ? 1'b1 : 1'b0);
    end
  end

  a_r8_queue_room: assert property (@(posedge clk) disable iff (rst)
    close |-> qn != (CHW+1)'(NCH));

  a_r7_chunk_starts_hdr: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> out_hdr);

  a_r4_hdr_then_sample: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_hdr |=> out_valid && !out_hdr);

  a_r6_count_range: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_hdr |-> out_data[CW-1:0] >= CW'(3) && out_data[CW-1:0] <= CW'(MAXS));
endmodule

// File: tb/tb_wave_chunker.sv
module tb_wave_chunker;
  logic clk = 0, rst = 1;
  logic in_valid = 0, thr_we = 0;
  logic [4:0] in_chan = 0, thr_ch = 0;
  logic [9:0] in_data = 0, thr_val = 0;
  logic out_valid, out_hdr;
  logic [30:0] out_data;

  wave_chunker dut (.clk(clk), .rst(rst), .in_valid(in_valid), .in_chan(in_chan),
    .in_data(in_data), .thr_we(thr_we), .thr_ch(thr_ch), .thr_val(thr_val),
    .out_valid(out_valid), .out_hdr(out_hdr), .out_data(out_data));

  always #5 clk = ~clk;

  int compared = 0, mismatched = 0;
  string cur_req = "R1";
  int wave [32];

  int m_thr [32], m_d1 [32], m_d2 [32], m_ts [32];
  bit m_act [32], m_pend [32];
  int m_cur [32][$];
  int wq [$], lq [$], cw [$];
  int frame = 0;
  bit mb = 0; int mi = 0, mch = 0;
  bit ev = 0, eh = 0; int ed = 0;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 32; i++) begin
        m_thr[i] = 1023; m_d1[i] = 0; m_d2[i] = 0; m_ts[i] = 0;
        m_act[i] = 0; m_pend[i] = 0; m_cur[i].delete();
      end
      wq.delete(); lq.delete(); cw.delete();
      frame = 0; mb = 0; mi = 0; ev = 0; eh = 0;
    end else begin
      bit popok;
      ev = mb; eh = mb && mi == 0;
      if (mb) ed = cw[mi];
      popok = lq.size() > 0;
      if (in_valid) begin
        int ch, s; bit ab;
        ch = in_chan; s = in_data; ab = s > m_thr[ch];
        if (!m_act[ch]) begin
          if (ab && !m_pend[ch]) begin
            m_cur[ch].delete();
            m_cur[ch].push_back(m_d2[ch]); m_cur[ch].push_back(m_d1[ch]);
            m_cur[ch].push_back(s);
            m_ts[ch] = (frame - 2) & 20'hFFFFF; m_act[ch] = 1;
          end
        end else begin
          m_cur[ch].push_back(s);
          if (!ab || m_cur[ch].size() == 32) begin
            int n; n = m_cur[ch].size();
            wq.push_back((ch << 26) | (m_ts[ch] << 6) | n);
            foreach (m_cur[ch][k]) wq.push_back(m_cur[ch][k]);
            lq.push_back(n + 1);
            m_act[ch] = 0; m_pend[ch] = 1;
          end
        end
        m_d2[ch] = m_d1[ch]; m_d1[ch] = s;
        if (ch == 31) frame = (frame + 1) & 20'hFFFFF;
      end
      if (thr_we) m_thr[thr_ch] = thr_val;
      if (!mb && popok) begin
        int n; n = lq.pop_front(); cw.delete();
        for (int k = 0; k < n; k++) cw.push_back(wq.pop_front());
        mch = cw[0] >> 26; mb = 1; mi = 0;
      end else if (mb) begin
        if (mi == cw.size() - 1) begin mb = 0; m_pend[mch] = 0; end
        else mi++;
      end
    end
  end

  always @(negedge clk) if (!rst) begin
    compared++;
    if (out_valid !== ev) begin
      mismatched++; $display("FAIL %s out_valid actual %0b expected %0b", cur_req, out_valid, ev);
    end
    compared++;
    if (out_hdr !== eh) begin
      mismatched++; $display("FAIL %s out_hdr actual %0b expected %0b", cur_req, out_hdr, eh);
    end
    if (ev) begin
      compared++;
      if (out_data !== 31'(ed)) begin
        mismatched++; $display("FAIL %s out_data actual %h expected %h", cur_req, out_data, ed);
      end
    end
  end

  task automatic run_frame(input int gap);
    for (int i = 0; i < 32; i++) begin
      @(negedge clk); in_valid = 1; in_chan = 5'(i); in_data = 10'(wave[i]);
      if (gap > 0 && i % 8 == 7) begin
        @(negedge clk); in_valid = 0;
      end
    end
    @(negedge clk); in_valid = 0;
  endtask

  task automatic base();
    for (int i = 0; i < 32; i++) wave[i] = 10 + i;
  endtask

  task automatic set_thr(input int ch, input int v);
    @(negedge clk); thr_we = 1; thr_ch = 5'(ch); thr_val = 10'(v);
    @(negedge clk); thr_we = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    compared++;
    if (out_valid !== 1'b0) begin
      mismatched++; $display("FAIL R1 reset out_valid actual %0b expected 0", out_valid);
    end
    cur_req = "R1";
    for (int i = 0; i < 32; i++) wave[i] = 1023;
    run_frame(0); run_frame(1); base(); run_frame(0); idle(10);

    cur_req = "R9";
    for (int i = 0; i < 32; i++) set_thr(i, 100 + i);
    set_thr(20, 500);
    base(); wave[20] = 300; run_frame(0); run_frame(0); idle(10);
    base(); run_frame(0); run_frame(0);

    cur_req = "R2";
    base(); wave[3] = 103; run_frame(0);
    base(); wave[3] = 104; run_frame(0);
    base(); run_frame(0); idle(60);

    cur_req = "R3";
    base(); wave[5] = 20; run_frame(1);
    base(); wave[5] = 30; run_frame(0);
    base(); wave[5] = 200; run_frame(0);
    base(); wave[5] = 300; run_frame(1);
    base(); wave[5] = 150; run_frame(0);
    base(); wave[5] = 40; run_frame(0);
    base(); run_frame(0); idle(40);

    cur_req = "R10";
    for (int f = 0; f < 6; f++) begin
      base();
      if (f >= 1 && f <= 3) wave[1] = 400 + f;
      if (f >= 1 && f <= 2) wave[9] = 600 - f;
      if (f >= 2 && f <= 4) wave[30] = 700 + f;
      run_frame(f % 2);
    end
    idle(80);

    cur_req = "R7";
    for (int f = 0; f < 5; f++) begin
      base();
      if (f >= 1 && f <= 2) wave[10] = 900;
      if (f >= 1 && f <= 3) wave[2] = 800 + f;
      run_frame(0);
    end
    idle(80);

    cur_req = "R6";
    for (int f = 0; f < 36; f++) begin
      base(); wave[7] = 200 + f; run_frame(0);
    end
    base(); run_frame(0); idle(60);

    cur_req = "R8";
    for (int f = 0; f < 8; f++) begin
      base();
      for (int i = 0; i < 32; i += 3) wave[i] = (f % 2 == 0) ? 900 : 20;
      run_frame(0);
    end
    base(); run_frame(0); idle(400);

    cur_req = "R5";
    for (int f = 0; f < 40; f++) begin
      base(); if (f % 5 == 2) wave[f % 32] = 1000; run_frame(f % 3 == 0);
    end
    idle(100);

    cur_req = "R4";
    base(); wave[31] = 1022; run_frame(0); base(); run_frame(0); idle(40);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule